// File: doc/BRIEF.md
# Audio Bus Master Global Reset and Interrupt Controller

This block is the global front end of a three-channel audio bus master with input, output and microphone channels. It holds the global control word, the global status word and a one-byte codec-access semaphore. It decides whether any register write is allowed to land, and it signals that decision to the channel register files on `wr_pass`. It issues reset pulses to the channels and folds the per-channel interrupt requests into status bits and one level interrupt line.

After hardware reset the control word is zero, so the bus master starts in cold reset. In that state the only write that takes effect is a 32-bit write to the control word. Software leaves cold reset by setting the cold-reset bit, which is active low. Software can request a warm reset. The block clears the warm-reset bit by itself, and it does nothing when any channel is streaming.

Top module: `agc_glob_ctrl`

## Requirements
- R1: After reset the control word reads 0, the semaphore reads 0, the status word reads `GSTA_RST` with every channel field bit at 0, `irq` is 0, and `chan_rst` is 0.
- R2: While control bit 1 is 0 (cold reset), a write has no effect and `wr_pass` is 0, unless it is a 32-bit write (`wr_size` = 2'b10) to the control address. A control write of any other size (byte 2'b00, word 2'b01) is ignored at all times.
- R3: An accepted control write with bit 1 clear does three things in the cycle of the write: it asserts all `chan_rst` bits for that one cycle, clears the semaphore, and stores the written value ANDed with `STABLE_MASK` (default 0x70).
- R4: An accepted control write with bit 1 set and bit 2 clear stores the value unchanged. For example, 0x72 reads back as 0x72.
- R5: An accepted control write with bits 1 and 2 set, made while `chan_running` is all zero, pulses every `chan_rst` bit in the write cycle and stores the value with bit 2 cleared. For example, 0x76 reads back as 0x72.
- R6: The same warm-reset write, made while any `chan_running` bit is 1, pulses no channel reset and stores the value unchanged.
- R7: Status bit `STS_LSB`+i (bits 5, 6, 7 for input 0, output 1, microphone 2) equals channel i's interrupt request sampled at the previous clock edge.
- R8: A byte write (`wr_size` = 2'b00) to the semaphore address outside cold reset stores the byte. The semaphore reads back zero-extended.
- R9: `irq` is 1 exactly when the status bit of the input or output channel is set. The microphone status bit does not drive `irq`.
- R10: The status word is read-only. Writes to its address leave it unchanged.
- R11: `wr_pass` is 1 for every write outside cold reset, and for a 32-bit control write during cold reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_size | input | 2 | Access size: 00 byte, 01 word, 10 32-bit |
| wr_data | input | 32 | Write data, low-aligned |
| rd_addr | input | 8 | Read address (combinational read) |
| rd_data | output | 32 | Read data, 0 for unmapped addresses |
| chan_running | input | 3 | Per-channel streaming flag (0 input, 1 output, 2 microphone) |
| chan_irq_req | input | 3 | Per-channel interrupt request level |
| chan_rst | output | 3 | Per-channel reset pulse, one cycle |
| wr_pass | output | 1 | Write allowed to reach channel registers |
| irq | output | 1 | Level interrupt line |

## Verification
The control word is written with values that differ only in bits 1 and 2. These writes are made once with all channels idle and once with the output channel streaming. Together they separate a cold reset, a plain store, a completed warm reset and a blocked warm reset by their read-back value and by whether `chan_rst` pulses. The gate is tested with byte and word writes during cold reset and with writes that do not target the control word. Each channel's interrupt request is raised alone, so that the microphone's status bit is shown to set without raising `irq`.

// File: rtl/agc_pkg.sv
package agc_pkg;
    localparam int REG_W    = 32;
    localparam int SEMA_W   = 8;
    localparam int COLD_BIT = 1;
    localparam int WARM_BIT = 2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic [REG_W-1:0]  ctl;
        logic [SEMA_W-1:0] sema;
    } ctl_state_t;
endpackage

// File: rtl/agc_ctl_regs.sv
module agc_ctl_regs
    import agc_pkg::*;
#(
    parameter int AW          = 8,
    parameter int NCH         = 3,
    parameter int CTL_ADDR    = 8'h00,
    parameter int SEMA_ADDR   = 8'h08,
    parameter logic [31:0] STABLE_MASK = 32'h0000_0070
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [1:0]        wr_size,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [NCH-1:0]    chan_running,
    output logic [REG_W-1:0]  ctl_q,
    output logic [SEMA_W-1:0] sema_q,
    output logic [NCH-1:0]    chan_rst,
    output logic              wr_pass
);
    localparam logic [AW-1:0]    CTL_A    = AW'(CTL_ADDR);
    localparam logic [AW-1:0]    SEMA_A   = AW'(SEMA_ADDR);
    localparam logic [REG_W-1:0] WARM_CLR = ~(REG_W'(1) << WARM_BIT);

    ctl_state_t st_d, st_q;
    logic       cold, ctl_hit, sema_hit;

    always_comb begin
        st_d     = st_q;
        chan_rst = '0;
        cold     = !st_q.ctl[COLD_BIT];
        ctl_hit  = wr_en && (wr_addr == CTL_A) && (wr_size == SZ_LONG);
        sema_hit = wr_en && !cold && (wr_addr == SEMA_A) && (wr_size == SZ_BYTE);
        wr_pass  = wr_en && (!cold || ctl_hit);
        if (ctl_hit) begin
            if (!wr_data[COLD_BIT]) begin
                st_d.ctl  = wr_data & STABLE_MASK;
                st_d.sema = '0;
                chan_rst  = '1;
            end else if (wr_data[WARM_BIT] && !(|chan_running)) begin
                st_d.ctl  = wr_data & WARM_CLR;
                chan_rst  = '1;
            end else begin
                st_d.ctl  = wr_data;
            end
        end else if (sema_hit) begin
            st_d.sema = wr_data[SEMA_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl_q  = st_q.ctl;
    assign sema_q = st_q.sema;

    assert_cold_sema_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ctl[COLD_BIT] |-> (st_q.sema == '0));

    assert_warm_needs_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ctl[WARM_BIT]) |-> $past(|chan_running));

    assert_rst_clears_warm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|chan_rst) |=> !st_q.ctl[WARM_BIT]);

    assert_cold_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctl[COLD_BIT] && !(wr_en && wr_addr == CTL_A && wr_size == SZ_LONG))
        |=> $stable(st_q));
endmodule

// File: rtl/agc_irq_stat.sv
module agc_irq_stat
    import agc_pkg::*;
#(
    parameter int NCH     = 3,
    parameter int STS_LSB = 5,
    parameter logic [31:0] GSTA_RST = 32'h0000_0100,
    parameter logic [2:0]  IRQ_CHAN_MASK = 3'b011
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   chan_irq_req,
    output logic [REG_W-1:0] gsta_q,
    output logic             irq
);
    localparam logic [REG_W-1:0] FIELD = REG_W'({NCH{1'b1}}) << STS_LSB;
    localparam logic [REG_W-1:0] RST_V = GSTA_RST & ~FIELD;

    logic [REG_W-1:0] gsta_d;
    logic [NCH-1:0]   contrib;

    always_comb begin
        gsta_d = gsta_q;
        gsta_d[STS_LSB +: NCH] = chan_irq_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gsta_q <= RST_V;
        else        gsta_q <= gsta_d;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        if (IRQ_CHAN_MASK[i]) begin : g_on
            assign contrib[i] = gsta_q[STS_LSB + i];
        end else begin : g_off
            assign contrib[i] = 1'b0;
        end
    end

    assign irq = |contrib;

    assert_sts_follows_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (gsta_q[STS_LSB +: NCH] == $past(chan_irq_req)));

    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(|(chan_irq_req & NCH'(IRQ_CHAN_MASK))));

    assert_fixed_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((gsta_q & ~FIELD) == RST_V));
endmodule

// File: rtl/agc_rd_mux.sv
module agc_rd_mux
    import agc_pkg::*;
#(
    parameter int AW        = 8,
    parameter int CTL_ADDR  = 8'h00,
    parameter int STS_ADDR  = 8'h04,
    parameter int SEMA_ADDR = 8'h08
) (
    input  logic [AW-1:0]     rd_addr,
    input  logic [REG_W-1:0]  ctl_q,
    input  logic [REG_W-1:0]  gsta_q,
    input  logic [SEMA_W-1:0] sema_q,
    output logic [REG_W-1:0]  rd_data
);
    always_comb begin
        if (rd_addr == AW'(CTL_ADDR))       rd_data = ctl_q;
        else if (rd_addr == AW'(STS_ADDR))  rd_data = gsta_q;
        else if (rd_addr == AW'(SEMA_ADDR)) rd_data = REG_W'(sema_q);
        else                                rd_data = '0;
    end
endmodule

// File: rtl/agc_glob_ctrl.sv
module agc_glob_ctrl
    import agc_pkg::*;
#(
    parameter int AW        = 8,
    parameter int NCH       = 3,
    parameter int CTL_ADDR  = 8'h00,
    parameter int STS_ADDR  = 8'h04,
    parameter int SEMA_ADDR = 8'h08,
    parameter int STS_LSB   = 5,
    parameter logic [31:0] STABLE_MASK   = 32'h0000_0070,
    parameter logic [31:0] GSTA_RST      = 32'h0000_0100,
    parameter logic [2:0]  IRQ_CHAN_MASK = 3'b011
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [1:0]      wr_size,
    input  logic [31:0]     wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [31:0]     rd_data,
    input  logic [NCH-1:0]  chan_running,
    input  logic [NCH-1:0]  chan_irq_req,
    output logic [NCH-1:0]  chan_rst,
    output logic            wr_pass,
    output logic            irq
);
    logic [REG_W-1:0]  ctl_q, gsta_q;
    logic [SEMA_W-1:0] sema_q;

    agc_ctl_regs #(
        .AW(AW), .NCH(NCH), .CTL_ADDR(CTL_ADDR), .SEMA_ADDR(SEMA_ADDR),
        .STABLE_MASK(STABLE_MASK)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_size(wr_size), .wr_data(wr_data), .chan_running(chan_running),
        .ctl_q(ctl_q), .sema_q(sema_q), .chan_rst(chan_rst), .wr_pass(wr_pass)
    );

    agc_irq_stat #(
        .NCH(NCH), .STS_LSB(STS_LSB), .GSTA_RST(GSTA_RST),
        .IRQ_CHAN_MASK(IRQ_CHAN_MASK)
    ) u_sts (
        .clk(clk), .rst_n(rst_n), .chan_irq_req(chan_irq_req),
        .gsta_q(gsta_q), .irq(irq)
    );

    agc_rd_mux #(
        .AW(AW), .CTL_ADDR(CTL_ADDR), .STS_ADDR(STS_ADDR), .SEMA_ADDR(SEMA_ADDR)
    ) u_rd (
        .rd_addr(rd_addr), .ctl_q(ctl_q), .gsta_q(gsta_q), .sema_q(sema_q),
        .rd_data(rd_data)
    );
endmodule

// File: tb/agc_glob_ctrl_tb_top.sv
module agc_glob_ctrl_tb_top;
    localparam logic [7:0]  A_CTL  = 8'h00;
    localparam logic [7:0]  A_STS  = 8'h04;
    localparam logic [7:0]  A_SEMA = 8'h08;
    localparam logic [31:0] GRST   = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [1:0]  wr_size = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [2:0]  chan_running = '0;
    logic [2:0]  chan_irq_req = '0;
    logic [2:0]  chan_rst;
    logic        wr_pass, irq;

    int checks = 0;
    int failures = 0;
    logic [2:0] rst_seen;
    logic       pass_seen;

    always #2 clk = ~clk;

    agc_glob_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_size(wr_size), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .chan_running(chan_running), .chan_irq_req(chan_irq_req),
        .chan_rst(chan_rst), .wr_pass(wr_pass), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_size = sz; wr_data = d;
        #1;
        rst_seen  = chan_rst;
        pass_seen = wr_pass;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CTL, v);  chk("R1 ctl", v, 32'h0);
        rd(A_SEMA, v); chk("R1 sema", v, 32'h0);
        rd(A_STS, v);  chk("R1 sts", v, GRST);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 chan_rst", {29'b0, chan_rst}, 32'h0);
    endtask

    task automatic t_cold_gate();
        logic [31:0] v;
        wr(A_SEMA, 2'b00, 32'hA5);
        chk("R2 pass sema cold", {31'b0, pass_seen}, 32'h0);
        rd(A_SEMA, v); chk("R2 sema cold", v, 32'h0);
        wr(A_CTL, 2'b01, 32'h2);
        chk("R2 word ctl cold", {31'b0, pass_seen}, 32'h0);
        rd(A_CTL, v); chk("R2 ctl word", v, 32'h0);
        wr(A_CTL, 2'b00, 32'h2);
        rd(A_CTL, v); chk("R2 ctl byte", v, 32'h0);
    endtask

    task automatic t_release();
        logic [31:0] v;
        wr(A_CTL, 2'b10, 32'h2);
        chk("R11 pass ctl cold", {31'b0, pass_seen}, 32'h1);
        rd(A_CTL, v); chk("R4 release", v, 32'h2);
        wr(A_CTL, 2'b10, 32'h72);
        chk("R4 no rst", {29'b0, rst_seen}, 32'h0);
        rd(A_CTL, v); chk("R4 enables", v, 32'h72);
        wr(A_CTL, 2'b01, 32'h0);
        rd(A_CTL, v); chk("R2 word ctl ignored", v, 32'h72);
    endtask

    task automatic t_sema();
        logic [31:0] v;
        wr(A_SEMA, 2'b00, 32'hFFFF_FFA5);
        chk("R11 pass sema", {31'b0, pass_seen}, 32'h1);
        rd(A_SEMA, v); chk("R8 sema", v, 32'hA5);
        wr(8'h40, 2'b01, 32'h1234);
        chk("R11 pass other", {31'b0, pass_seen}, 32'h1);
    endtask

    task automatic t_warm_idle();
        logic [31:0] v;
        chan_running = 3'b000;
        wr(A_CTL, 2'b10, 32'h76);
        chk("R5 rst pulse", {29'b0, rst_seen}, 32'h7);
        chk("R5 rst gone", {29'b0, chan_rst}, 32'h0);
        rd(A_CTL, v); chk("R5 selfclear", v, 32'h72);
    endtask

    task automatic t_warm_busy();
        logic [31:0] v;
        chan_running = 3'b010;
        wr(A_CTL, 2'b10, 32'h76);
        chk("R6 no pulse", {29'b0, rst_seen}, 32'h0);
        rd(A_CTL, v); chk("R6 kept", v, 32'h76);
        chan_running = 3'b000;
        wr(A_CTL, 2'b10, 32'h72);
    endtask

    task automatic t_cold_write();
        logic [31:0] v;
        wr(A_SEMA, 2'b00, 32'h5A);
        rd(A_SEMA, v); chk("R8 sema again", v, 32'h5A);
        wr(A_CTL, 2'b10, 32'h0000_FF74);
        chk("R3 rst pulse", {29'b0, rst_seen}, 32'h7);
        rd(A_CTL, v);  chk("R3 stable bits", v, 32'h70);
        rd(A_SEMA, v); chk("R3 sema cleared", v, 32'h0);
        wr(A_CTL, 2'b10, 32'h2);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        @(negedge clk); chan_irq_req = 3'b001;
        #1; chk("R7 not yet", {31'b0, irq}, 32'h0);
        @(negedge clk); #1;
        rd(A_STS, v); chk("R7 input sts", v, GRST | 32'h20);
        chk("R9 input irq", {31'b0, irq}, 32'h1);
        @(negedge clk); chan_irq_req = 3'b100;
        @(negedge clk); #1;
        rd(A_STS, v); chk("R7 mic sts", v, GRST | 32'h80);
        chk("R9 mic no irq", {31'b0, irq}, 32'h0);
        @(negedge clk); chan_irq_req = 3'b010;
        @(negedge clk); #1;
        rd(A_STS, v); chk("R7 output sts", v, GRST | 32'h40);
        chk("R9 output irq", {31'b0, irq}, 32'h1);
        wr(A_STS, 2'b10, 32'h0);
        rd(A_STS, v); chk("R10 sts ro", v, GRST | 32'h40);
        @(negedge clk); chan_irq_req = 3'b000;
        @(negedge clk); #1;
        rd(A_STS, v); chk("R7 cleared", v, GRST);
        chk("R9 irq low", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_cold_gate();
        t_release();
        t_sema();
        t_warm_idle();
        t_warm_busy();
        t_cold_write();
        t_irq();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 100000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule